// File: doc/BRIEF.md
# Encode Accelerator Host Interface

This block sits between a host register port and a task-driven video encode engine. The host queues work by writing two words per task to a single push address. The first word is a header that carries a task tag, a client tag and a command type. The second word is the address of the task descriptor. The block pairs the two words and keeps the pair as one command-queue entry. It offers that entry to the engine on a valid/ready command port, and it holds back encode commands while the matching engine clock enable is clear.

The engine returns tagged completion records on a second valid/ready port. The block stores them in a status queue that the host drains by reading one address, and every stored record raises a status interrupt. If a command is paired while the command queue is full, the block drops that command and queues a "list full" record in its place. Three memory-fault inputs are captured into sticky error registers, and a capture raises a separate error interrupt. The block also holds plain configuration registers, a three-bit engine clock-enable register and a read-only version word.

Top module: `enc_host_if`

## Requirements
- R1: After reset both interrupt lines are low, the clock enables are 0, both queue levels read 0 and the engine command port is not valid.
- R2: A header write to 0x114 alone does not change the command level at 0x110. The descriptor write that follows adds exactly one entry, and the engine port then presents the header and descriptor together and holds them until accepted.
- R3: Bits [2:0] written to 0x148 drive the clock-enable outputs and read back. A command whose type byte (header bits [7:0]) is 0x01 (encode) is offered to the engine only while bit 0 is set. Other types are offered regardless of that bit.
- R4: Each accepted engine completion adds one status entry. Reads of 0x118 return the entries oldest first and remove them, and a read of 0x118 while the queue is empty returns 0. Address 0x11C returns the number of pending status entries in bits [3:0].
- R5: Storing a status entry sets the status interrupt. A write of bit 0 = 1 to 0x120 clears both the status and the error interrupt.
- R6: When a descriptor write completes a pair while the command queue holds all its entries, the command is dropped and the level stays the same. A status entry is queued with bits [31:8] taken from that command's header and status code 0xF0 in bits [7:0].
- R7: Fault words on the local (0x128), external (0x12C) and secondary (0x130) memory channels are latched only when they are nonzero and the register is still zero. A later fault does not overwrite a held value, and each latch sets the error interrupt.
- R8: A write of bit 0 = 1 to 0x124 clears all three fault registers and the error interrupt.
- R9: Any write to 0x100 drops a half-written command and empties both queues. It also sets bit 0 of 0x104.
- R10: Offset 0x14C reads the version identifier in bits [15:0] with zero above it and ignores writes. Offsets 0x108, 0x10C and 0x150 read back the last value written.
- R11: While the status queue is full, the completion port's ready is low and the status level stays at the queue depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Access accepted (always high) |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| eng_cmd_valid | output | 1 | Command offered to the engine |
| eng_cmd_ready | input | 1 | Engine takes the command |
| eng_cmd_header | output | 32 | Command header word |
| eng_cmd_desc | output | 32 | Task descriptor address |
| eng_cpl_valid | input | 1 | Completion record offered |
| eng_cpl_ready | output | 1 | Completion record accepted |
| eng_cpl_word | input | 32 | Completion record |
| fault_valid | input | 3 | Per-channel fault strobe (0 local, 1 external, 2 secondary) |
| fault_word | input | 96 | Per-channel fault words, channel i at [32i+31:32i] |
| irq_status | output | 1 | Status interrupt |
| irq_error | output | 1 | Error interrupt |
| clk_en | output | 3 | Engine clock enables |

## Verification
The hardest situation to reach is the drop on a full list. It requires a full command queue and a blocked engine at the moment a descriptor write completes a pair. The bench sets the encode clock enable, holds the engine's ready low, and pairs one more command than the queue can hold. It then pops the status queue and checks the echoed tags and the 0xF0 code. It fills the status queue with completions the same way to show the back-pressure on the completion port.

// File: rtl/enc_host_if_pkg.sv
package enc_host_if_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WORD_W = 32;

  localparam logic [ADDR_W-1:0] OFS_SOFT_RST  = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_RST_DONE  = 12'h104;
  localparam logic [ADDR_W-1:0] OFS_MEMCFG_A  = 12'h108;
  localparam logic [ADDR_W-1:0] OFS_MEMCFG_B  = 12'h10C;
  localparam logic [ADDR_W-1:0] OFS_CMD_LVL   = 12'h110;
  localparam logic [ADDR_W-1:0] OFS_CMD_PUSH  = 12'h114;
  localparam logic [ADDR_W-1:0] OFS_STS_POP   = 12'h118;
  localparam logic [ADDR_W-1:0] OFS_STS_LVL   = 12'h11C;
  localparam logic [ADDR_W-1:0] OFS_IRQ_ACK   = 12'h120;
  localparam logic [ADDR_W-1:0] OFS_ERR_ACK   = 12'h124;
  localparam logic [ADDR_W-1:0] OFS_FLT_LOC   = 12'h128;
  localparam logic [ADDR_W-1:0] OFS_FLT_EXT   = 12'h12C;
  localparam logic [ADDR_W-1:0] OFS_FLT_SEC   = 12'h130;
  localparam logic [ADDR_W-1:0] OFS_GATE      = 12'h148;
  localparam logic [ADDR_W-1:0] OFS_VERSION   = 12'h14C;
  localparam logic [ADDR_W-1:0] OFS_SWAPCFG   = 12'h150;

  localparam logic [7:0] CMD_TYPE_ENCODE = 8'h01;
  localparam logic [7:0] STS_LIST_FULL   = 8'hF0;
endpackage

// File: rtl/hif_fifo.sv
module hif_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push && !full) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop && !empty) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(push && !full) - CW'(pop && !empty);
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/hif_cmd_pair.sv
module hif_cmd_pair #(
  parameter int unsigned WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                wr_push,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                queue_full,
  output logic                push,
  output logic [2*WORD_W-1:0] push_data,
  output logic                drop,
  output logic [WORD_W-1:0]   drop_record
);
  import enc_host_if_pkg::*;

  logic              half;
  logic [WORD_W-1:0] hdr_q;

  assign push        = wr_push && half && !queue_full;
  assign drop        = wr_push && half && queue_full;
  assign push_data   = {hdr_q, wdata};
  assign drop_record = {hdr_q[WORD_W-1:8], STS_LIST_FULL};

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      half  <= 1'b0;
      hdr_q <= '0;
    end else if (wr_push) begin
      half <= !half;
      if (!half) hdr_q <= wdata;
    end
  end
endmodule

// File: rtl/hif_err_capture.sv
module hif_err_capture #(
  parameter int unsigned N      = 3,
  parameter int unsigned WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic [N-1:0]        fault_valid,
  input  logic [N*WORD_W-1:0] fault_word,
  output logic [N*WORD_W-1:0] held,
  output logic                latched
);
  logic [N-1:0] take;

  for (genvar i = 0; i < N; i++) begin : g_chan
    logic [WORD_W-1:0] cap_q;
    logic [WORD_W-1:0] w;
    assign w       = fault_word[i*WORD_W +: WORD_W];
    assign take[i] = !clr && fault_valid[i] && (w != '0) && (cap_q == '0);
    assign held[i*WORD_W +: WORD_W] = cap_q;

    always_ff @(posedge clk) begin
      if (rst || clr)   cap_q <= '0;
      else if (take[i]) cap_q <= w;
    end

    a_r7_hold_first: assert property (@(posedge clk) disable iff (rst)
      (cap_q != '0 && !clr) |=> (cap_q == $past(cap_q)));
  end

  assign latched = |take;
endmodule

// File: rtl/enc_host_if.sv
module enc_host_if #(
  parameter int unsigned CMD_DEPTH  = 4,
  parameter int unsigned STS_DEPTH  = 8,
  parameter int unsigned N_FAULT    = 3,
  parameter logic [15:0] VERSION_ID = 16'h0A15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_valid,
  output logic                  reg_ready,
  input  logic                  reg_write,
  input  logic [11:0]           reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic                  rd_valid,
  output logic [31:0]           rd_data,
  output logic                  eng_cmd_valid,
  input  logic                  eng_cmd_ready,
  output logic [31:0]           eng_cmd_header,
  output logic [31:0]           eng_cmd_desc,
  input  logic                  eng_cpl_valid,
  output logic                  eng_cpl_ready,
  input  logic [31:0]           eng_cpl_word,
  input  logic [N_FAULT-1:0]    fault_valid,
  input  logic [N_FAULT*32-1:0] fault_word,
  output logic                  irq_status,
  output logic                  irq_error,
  output logic [2:0]            clk_en
);
  import enc_host_if_pkg::*;

  localparam int unsigned CCW = $clog2(CMD_DEPTH + 1);
  localparam int unsigned SCW = $clog2(STS_DEPTH + 1);

  logic wr, rd;
  assign reg_ready = 1'b1;
  assign wr = reg_valid && reg_write;
  assign rd = reg_valid && !reg_write;

  logic soft_clr, it_ack, err_ack, gate_wr;
  assign soft_clr = wr && (reg_addr == OFS_SOFT_RST);
  assign it_ack   = wr && (reg_addr == OFS_IRQ_ACK) && reg_wdata[0];
  assign err_ack  = wr && (reg_addr == OFS_ERR_ACK) && reg_wdata[0];
  assign gate_wr  = wr && (reg_addr == OFS_GATE);

  // command pairing and queue
  logic        pair_push, pair_drop;
  logic [63:0] pair_data, cmd_head;
  logic [31:0] drop_rec;
  logic        cmd_full, cmd_empty, cmd_pop;
  logic [CCW-1:0] cmd_count;

  hif_cmd_pair #(.WORD_W(32)) u_pair (
    .clk(clk), .rst(rst), .flush(soft_clr),
    .wr_push(wr && (reg_addr == OFS_CMD_PUSH)), .wdata(reg_wdata),
    .queue_full(cmd_full), .push(pair_push), .push_data(pair_data),
    .drop(pair_drop), .drop_record(drop_rec)
  );

  hif_fifo #(.W(64), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk(clk), .rst(rst), .flush(soft_clr),
    .push(pair_push), .din(pair_data), .pop(cmd_pop),
    .dout(cmd_head), .count(cmd_count), .full(cmd_full), .empty(cmd_empty)
  );

  logic [2:0] gate_q;
  assign clk_en         = gate_q;
  assign eng_cmd_header = cmd_head[63:32];
  assign eng_cmd_desc   = cmd_head[31:0];
  assign eng_cmd_valid  = !cmd_empty &&
                          ((cmd_head[39:32] != CMD_TYPE_ENCODE) || gate_q[0]);
  assign cmd_pop        = eng_cmd_valid && eng_cmd_ready && !soft_clr;

  // status queue
  logic        sts_full, sts_empty, sts_push, sts_pop, cpl_fire, drop_push;
  logic [31:0] sts_din, sts_head;
  logic [SCW-1:0] sts_count;

  assign eng_cpl_ready = !sts_full && !pair_drop && !soft_clr;
  assign cpl_fire      = eng_cpl_valid && eng_cpl_ready;
  assign drop_push     = pair_drop && !sts_full;
  assign sts_push      = cpl_fire || drop_push;
  assign sts_din       = pair_drop ? drop_rec : eng_cpl_word;
  assign sts_pop       = rd && (reg_addr == OFS_STS_POP) && !sts_empty;

  hif_fifo #(.W(32), .DEPTH(STS_DEPTH)) u_sts_q (
    .clk(clk), .rst(rst), .flush(soft_clr),
    .push(sts_push), .din(sts_din), .pop(sts_pop),
    .dout(sts_head), .count(sts_count), .full(sts_full), .empty(sts_empty)
  );

  // fault capture
  logic [N_FAULT*32-1:0] flt_held;
  logic                  flt_new;

  hif_err_capture #(.N(N_FAULT), .WORD_W(32)) u_err (
    .clk(clk), .rst(rst), .clr(err_ack),
    .fault_valid(fault_valid), .fault_word(fault_word),
    .held(flt_held), .latched(flt_new)
  );

  // interrupts and plain registers
  logic [31:0] cfg_a_q, cfg_b_q, swap_q;
  logic        rst_done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_status <= 1'b0;
      irq_error  <= 1'b0;
      gate_q     <= '0;
      cfg_a_q    <= '0;
      cfg_b_q    <= '0;
      swap_q     <= '0;
      rst_done_q <= 1'b0;
    end else begin
      if (sts_push)    irq_status <= 1'b1;
      else if (it_ack) irq_status <= 1'b0;
      if (flt_new)                irq_error <= 1'b1;
      else if (it_ack || err_ack) irq_error <= 1'b0;
      if (gate_wr) gate_q <= reg_wdata[2:0];
      if (wr && reg_addr == OFS_MEMCFG_A) cfg_a_q <= reg_wdata;
      if (wr && reg_addr == OFS_MEMCFG_B) cfg_b_q <= reg_wdata;
      if (wr && reg_addr == OFS_SWAPCFG)  swap_q  <= reg_wdata;
      if (soft_clr) rst_done_q <= 1'b1;
    end
  end

  // registered read path
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_RST_DONE: rd_mux = {31'b0, rst_done_q};
      OFS_MEMCFG_A: rd_mux = cfg_a_q;
      OFS_MEMCFG_B: rd_mux = cfg_b_q;
      OFS_CMD_LVL:  rd_mux = 32'(cmd_count);
      OFS_STS_POP:  rd_mux = sts_empty ? '0 : sts_head;
      OFS_STS_LVL:  rd_mux = {28'b0, 4'(sts_count)};
      OFS_FLT_LOC:  rd_mux = flt_held[31:0];
      OFS_FLT_EXT:  rd_mux = (N_FAULT > 1) ? flt_held[32 +: 32] : '0;
      OFS_FLT_SEC:  rd_mux = (N_FAULT > 2) ? flt_held[64 +: 32] : '0;
      OFS_GATE:     rd_mux = {29'b0, gate_q};
      OFS_VERSION:  rd_mux = {16'b0, VERSION_ID};
      OFS_SWAPCFG:  rd_mux = swap_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rd_mux;
    end
  end

  a_r3_encode_needs_gate: assert property (@(posedge clk) disable iff (rst)
    (eng_cmd_valid && eng_cmd_header[7:0] == CMD_TYPE_ENCODE) |-> clk_en[0]);
  a_r2_offer_held: assert property (@(posedge clk) disable iff (rst)
    (eng_cmd_valid && !eng_cmd_ready && !soft_clr && !gate_wr)
      |=> (eng_cmd_valid && $stable(eng_cmd_header) && $stable(eng_cmd_desc)));
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (it_ack && !sts_push && !flt_new) |=> (!irq_status && !irq_error));
  a_r6_drop_raises: assert property (@(posedge clk) disable iff (rst)
    drop_push |=> irq_status);
  a_r11_backpressure: assert property (@(posedge clk) disable iff (rst)
    (sts_full && !sts_pop && !soft_clr) |=> sts_full);
endmodule

// File: tb/enc_host_if_tb.sv
module enc_host_if_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        reg_valid = 0, reg_write = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ready, rd_valid;
  logic [31:0] rd_data;
  logic        eng_cmd_valid, eng_cmd_ready = 0;
  logic [31:0] eng_cmd_header, eng_cmd_desc;
  logic        eng_cpl_valid = 0, eng_cpl_ready;
  logic [31:0] eng_cpl_word = '0;
  logic [2:0]  fault_valid = '0;
  logic [95:0] fault_word = '0;
  logic        irq_status, irq_error;
  logic [2:0]  clk_en;

  enc_host_if u_dut (
    .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
    .eng_cmd_header(eng_cmd_header), .eng_cmd_desc(eng_cmd_desc),
    .eng_cpl_valid(eng_cpl_valid), .eng_cpl_ready(eng_cpl_ready),
    .eng_cpl_word(eng_cpl_word), .fault_valid(fault_valid),
    .fault_word(fault_word), .irq_status(irq_status), .irq_error(irq_error),
    .clk_en(clk_en)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    @(negedge clk);
    reg_valid = 0;
    d = rd_valid ? rd_data : 32'hBAD0BAD0;
  endtask

  task automatic eng_take();
    @(negedge clk); eng_cmd_ready = 1;
    @(negedge clk); eng_cmd_ready = 0;
  endtask

  task automatic complete(input logic [31:0] w);
    @(negedge clk); eng_cpl_valid = 1; eng_cpl_word = w;
    @(negedge clk); eng_cpl_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq_status", {31'b0, irq_status}, 0);
    check("R1 irq_error", {31'b0, irq_error}, 0);
    check("R1 clk_en", {29'b0, clk_en}, 0);
    check("R1 cmd valid", {31'b0, eng_cmd_valid}, 0);
    rd(12'h110, v); check("R1 cmd level", v, 0);
    rd(12'h11C, v); check("R1 sts level", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    rd(12'h14C, v); check("R10 version", v, 32'h0000_0A15);
    wr(12'h14C, 32'hFFFF_FFFF);
    rd(12'h14C, v); check("R10 version ro", v, 32'h0000_0A15);
    wr(12'h108, 32'h1234_5678); rd(12'h108, v); check("R10 cfg a", v, 32'h1234_5678);
    wr(12'h10C, 32'h0000_00C4); rd(12'h10C, v); check("R10 cfg b", v, 32'h0000_00C4);
    wr(12'h150, 32'h0003_F000); rd(12'h150, v); check("R10 swap", v, 32'h0003_F000);
  endtask

  task automatic t_pair();
    logic [31:0] v;
    wr(12'h114, 32'h1234_0301);
    rd(12'h110, v); check("R2 half cmd level", v, 0);
    wr(12'h114, 32'h8000_1000);
    rd(12'h110, v); check("R2 full cmd level", v, 1);
    check("R3 gated", {31'b0, eng_cmd_valid}, 0);
    wr(12'h148, 32'h5);
    check("R3 clk_en", {29'b0, clk_en}, 3'h5);
    rd(12'h148, v); check("R3 gate readback", v, 5);
    check("R3 offered", {31'b0, eng_cmd_valid}, 1);
    check("R2 header", eng_cmd_header, 32'h1234_0301);
    check("R2 desc", eng_cmd_desc, 32'h8000_1000);
    eng_take();
    rd(12'h110, v); check("R2 taken", v, 0);
    wr(12'h148, 32'h0);
    wr(12'h114, 32'h0077_0205); wr(12'h114, 32'h8000_2000);
    check("R3 other type offered", {31'b0, eng_cmd_valid}, 1);
    check("R3 other header", eng_cmd_header, 32'h0077_0205);
    eng_take();
  endtask

  task automatic t_status();
    logic [31:0] v;
    complete(32'h0001_0300); complete(32'h0002_0304); complete(32'h0003_0508);
    check("R5 irq set", {31'b0, irq_status}, 1);
    rd(12'h11C, v); check("R4 level 3", v, 3);
    rd(12'h118, v); check("R4 pop 0", v, 32'h0001_0300);
    rd(12'h118, v); check("R4 pop 1", v, 32'h0002_0304);
    rd(12'h118, v); check("R4 pop 2", v, 32'h0003_0508);
    rd(12'h118, v); check("R4 empty pop", v, 0);
    wr(12'h120, 32'h1);
    check("R5 irq cleared", {31'b0, irq_status}, 0);
  endtask

  task automatic t_full();
    logic [31:0] v;
    wr(12'h148, 32'h1);
    for (int i = 0; i < 4; i++) begin
      wr(12'h114, 32'h0010_0101 + (i << 16)); wr(12'h114, 32'h9000_0000 + i);
    end
    rd(12'h110, v); check("R6 queue full", v, 4);
    wr(12'h114, 32'h00AB_0201); wr(12'h114, 32'h9000_00FF);
    rd(12'h110, v); check("R6 level kept", v, 4);
    check("R6 irq", {31'b0, irq_status}, 1);
    rd(12'h11C, v); check("R6 sts level", v, 1);
    rd(12'h118, v); check("R6 drop record", v, 32'h00AB_02F0);
    wr(12'h120, 32'h1);
    complete(32'h0000_0100);
    wr(12'h114, 32'h0FFF_0101);
    wr(12'h100, 32'h0);
    rd(12'h110, v); check("R9 cmd emptied", v, 0);
    rd(12'h11C, v); check("R9 sts emptied", v, 0);
    rd(12'h104, v); check("R9 reset done", v, 1);
    wr(12'h114, 32'h0042_0301); wr(12'h114, 32'h9100_0000);
    rd(12'h110, v); check("R9 clean pairing", v, 1);
    check("R9 header after reset", eng_cmd_header, 32'h0042_0301);
    eng_take();
    wr(12'h120, 32'h1);
  endtask

  task automatic t_backpressure();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) complete(32'h0000_0100 + i);
    @(negedge clk); eng_cpl_valid = 1; eng_cpl_word = 32'hDEAD_0000;
    #1;
    check("R11 ready low", {31'b0, eng_cpl_ready}, 0);
    @(negedge clk); eng_cpl_valid = 0;
    rd(12'h11C, v); check("R11 level depth", v, 8);
    rd(12'h118, v); check("R11 oldest kept", v, 32'h0000_0100);
    wr(12'h100, 32'h0);
    wr(12'h120, 32'h1);
  endtask

  task automatic t_faults();
    logic [31:0] v;
    @(negedge clk); fault_valid = 3'b010; fault_word[63:32] = 32'hDEAD_0001;
    @(negedge clk); fault_valid = 3'b000;
    check("R7 irq_error", {31'b0, irq_error}, 1);
    rd(12'h12C, v); check("R7 ext latched", v, 32'hDEAD_0001);
    @(negedge clk); fault_valid = 3'b011; fault_word[63:32] = 32'h2; fault_word[31:0] = 32'h0;
    @(negedge clk); fault_valid = 3'b000;
    rd(12'h12C, v); check("R7 first kept", v, 32'hDEAD_0001);
    rd(12'h128, v); check("R7 zero ignored", v, 0);
    wr(12'h120, 32'h1);
    check("R5 ack clears error line", {31'b0, irq_error}, 0);
    @(negedge clk); fault_valid = 3'b100; fault_word[95:64] = 32'h0000_0C00;
    @(negedge clk); fault_valid = 3'b000;
    rd(12'h130, v); check("R7 sec latched", v, 32'h0000_0C00);
    check("R7 irq again", {31'b0, irq_error}, 1);
    wr(12'h124, 32'h1);
    check("R8 irq_error cleared", {31'b0, irq_error}, 0);
    rd(12'h12C, v); check("R8 ext cleared", v, 0);
    rd(12'h130, v); check("R8 sec cleared", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_regs();
    t_pair();
    t_status();
    t_full();
    t_backpressure();
    t_faults();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule